// File: doc/BRIEF.md
# Indexed Block-Transfer I2C Register Slave

This block is an I2C target that fronts a bank of five 8-bit control registers. Every transfer first addresses the block for writing and sends a starting index. For a write, the host then sends a byte count and that many data bytes, which land in consecutive registers from the index upward. For a read, the host issues a repeated start with the read address. The block answers with a count byte and then streams registers from the stored index upward until the host declines a byte.

Both bus lines are synchronised and pass through a filter that only accepts a level held for two samples. Start and stop conditions are recognised from SDA edges while the filtered SCL is high. SDA is modelled as an input plus an active-high pull-down enable. The block changes that enable only while SCL is low.

Two registers mix software-written bits with live readback of board pins: five frequency-select straps and a current-multiplier select. Every register's visible value is presented in parallel on a flat output bus.

Top module: `idx_i2c_regs`

## Requirements
- R1: After reset the register views are: byte 0 = 0x00, byte 1 low three bits = 3'b111, byte 2 = 0xFF, byte 3 = 0x37, byte 4 bits 6..0 = 0.
- R2: Only the address bytes 0xD2 (write) and 0xD3 (read) are acknowledged. After any other address the block leaves SDA released until the next start.
- R3: A write transfer (0xD2, index N, count X, then data) stores data byte k into register N+k for k < X and acknowledges every byte.
- R4: Data bytes sent after the first X are acknowledged but change no register.
- R5: Writes to an index of 5 or above are acknowledged and discarded. Reads from such an index return 0x00.
- R6: A read transfer (0xD3 after a start or repeated start) returns first the count X of the last count byte received (5 after reset), then registers from the stored index upward. It stops driving when the host answers a byte with NACK.
- R7: Byte 1 bits 7..3 always show strap inputs 4..0, and byte 4 bit 7 shows the multiplier-select input. Byte 4 bits 6..0 read 0. Writes to any of these bits have no effect.
- R8: A stop or a start in the middle of a transfer abandons it. Bytes already completed stay written, and the stored index stays as last set.
- R9: SDA is changed only while SCL is low, and an SCL pulse lasting one clock cycle is ignored.
- R10: Output byte k of `cfg_o` (bits 8k+7..8k) equals the value a read of register k returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | When high, the block pulls SDA low |
| strap_fs | input | 5 | Latched frequency-select straps for readback |
| mult_sel | input | 1 | Current-multiplier select pin for readback |
| cfg_o | output | 40 | Parallel view of all five registers |

## Verification
The bench covers several corner cases:
- Surplus data bytes beyond the count. A design that trusted the byte stream instead of the count would overwrite neighbouring registers.
- Indices past the bank end. Ignoring these would wrap writes onto register 0 or NACK the host.
- Readback bits, which a write mask error would let software overwrite.
- Transfers cut short by a stop or by a fresh start. The following index-less read shows whether the stored index was disturbed.
- One-clock SCL glitches injected mid-bit. A missing filter would shift a spurious bit and corrupt every later register.

// File: rtl/idx_i2c_regs.sv
module idx_i2c_regs #(
  parameter logic [7:0] WR_ADDR = 8'hD2,
  parameter logic [7:0] CNT_RST = 8'd5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [4:0]  strap_fs,
  input  logic        mult_sel,
  output logic [39:0] cfg_o
);
  localparam logic [7:0] RD_ADDR = WR_ADDR | 8'h01;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_HACK} st_t;
  typedef enum logic [1:0] {P_ADDR, P_IDX, P_CNT, P_DATA} ph_t;

  logic [2:0] scl_sh, sda_sh;
  logic       scl_f, sda_f, scl_d, sda_d;
  logic       rise, fall, start_ev, stop_ev, is_idle;

  st_t        st;
  ph_t        ph;
  logic [3:0] bcnt;
  logic [7:0] shr, txs, idx, ptr, rcnt, left;
  logic       ack, to_tx, hack;
  logic [7:0] r0, r2, r3;
  logic [2:0] r1en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
      scl_f  <= 1'b1;
      sda_f  <= 1'b1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
      if (scl_sh[2] == scl_sh[1]) scl_f <= scl_sh[1];
      if (sda_sh[2] == sda_sh[1]) sda_f <= sda_sh[1];
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  assign rise     = scl_f & ~scl_d;
  assign fall     = ~scl_f & scl_d;
  assign start_ev = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_ev  = scl_f & scl_d & ~sda_d & sda_f;
  assign is_idle  = (st == S_IDLE);

  function automatic logic [7:0] rd_val(input logic [7:0] p);
    case (p)
      8'd0:    rd_val = r0;
      8'd1:    rd_val = {strap_fs, r1en};
      8'd2:    rd_val = r2;
      8'd3:    rd_val = r3;
      8'd4:    rd_val = {mult_sel, 7'b0};
      default: rd_val = 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ph    <= P_ADDR;
      bcnt  <= '0;
      shr   <= '0;
      txs   <= 8'hFF;
      idx   <= '0;
      ptr   <= '0;
      rcnt  <= CNT_RST;
      left  <= '0;
      ack   <= 1'b0;
      to_tx <= 1'b0;
      hack  <= 1'b0;
      r0    <= 8'h00;
      r1en  <= 3'b111;
      r2    <= 8'hFF;
      r3    <= 8'h37;
    end else if (start_ev) begin
      st    <= S_RX;
      ph    <= P_ADDR;
      bcnt  <= '0;
      to_tx <= 1'b0;
      ack   <= 1'b0;
    end else if (stop_ev) begin
      st  <= S_IDLE;
      ack <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (rise) begin
            shr  <= {shr[6:0], sda_f};
            bcnt <= bcnt + 4'd1;
          end else if (fall && bcnt == 4'd8) begin
            st  <= S_ACK;
            ack <= 1'b1;
            case (ph)
              P_ADDR: begin
                if (shr == WR_ADDR) begin
                  ph <= P_IDX;
                end else if (shr == RD_ADDR) begin
                  to_tx <= 1'b1;
                  ptr   <= idx;
                end else begin
                  ack <= 1'b0;
                end
              end
              P_IDX: begin
                idx <= shr;
                ptr <= shr;
                ph  <= P_CNT;
              end
              P_CNT: begin
                rcnt <= shr;
                left <= shr;
                ph   <= P_DATA;
              end
              default: begin
                if (left != 8'd0) begin
                  left <= left - 8'd1;
                  ptr  <= ptr + 8'd1;
                  case (ptr)
                    8'd0:    r0   <= shr;
                    8'd1:    r1en <= shr[2:0];
                    8'd2:    r2   <= shr;
                    8'd3:    r3   <= shr;
                    default: ;
                  endcase
                end
              end
            endcase
          end
        end
        S_ACK: begin
          if (fall) begin
            bcnt <= '0;
            if (!ack) begin
              st <= S_IDLE;
            end else if (to_tx) begin
              st  <= S_TX;
              txs <= rcnt;
            end else begin
              st <= S_RX;
            end
            ack <= 1'b0;
          end
        end
        S_TX: begin
          if (rise) begin
            bcnt <= bcnt + 4'd1;
          end else if (fall) begin
            if (bcnt == 4'd8) st <= S_HACK;
            else txs <= {txs[6:0], 1'b1};
          end
        end
        S_HACK: begin
          if (rise) begin
            hack <= ~sda_f;
          end else if (fall) begin
            if (hack) begin
              st   <= S_TX;
              bcnt <= '0;
              txs  <= rd_val(ptr);
              ptr  <= ptr + 8'd1;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = ((st == S_ACK) && ack) || ((st == S_TX) && !txs[7]);
  assign cfg_o  = {rd_val(8'd4), rd_val(8'd3), rd_val(8'd2), rd_val(8'd1), rd_val(8'd0)};
endmodule

module idx_i2c_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_f,
  input logic        sda_oe,
  input logic        stop_ev,
  input logic        is_idle,
  input logic [4:0]  strap_fs,
  input logic        mult_sel,
  input logic [39:0] cfg_o
);
  // R9: the pull-down enable only moves while filtered SCL is low
  p_sda_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_f);

  // R8: a stop always leaves the line released
  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  // R3: writable register bits change only during SCL low
  p_write_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({cfg_o[31:16], cfg_o[10:0]}) |-> !scl_f);

  // R7: readback bits follow pins alone
  p_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(strap_fs) && $stable(mult_sel)) |-> $stable({cfg_o[39:32], cfg_o[15:11]}));

  // R2: an idle slave does not touch SDA
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle |-> !sda_oe);
endmodule

bind idx_i2c_regs idx_i2c_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe(sda_oe), .stop_ev(stop_ev),
  .is_idle(is_idle), .strap_fs(strap_fs), .mult_sel(mult_sel), .cfg_o(cfg_o)
);

// File: tb/idx_i2c_regs_test.sv
module idx_i2c_regs_test;
  localparam int CLK_NS = 10;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_h = 1'b1, glitch_en = 1'b0;
  logic sda_oe, sda_line, mult;
  logic [4:0] strap;
  logic [39:0] cfg;
  int checks = 0, fails = 0, sda_viol = 0;
  logic [7:0] m0 = 8'h00, m2 = 8'hFF, m3 = 8'h37, mcnt = 8'd5, midx = 8'd0;
  logic [2:0] m1en = 3'b111;
  logic [7:0] wd [8];
  logic prev_oe = 1'b0, prev_scl = 1'b1;

  assign sda_line = sda_h & ~sda_oe;

  idx_i2c_regs uut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
                    .strap_fs(strap), .mult_sel(mult), .cfg_o(cfg));

  always #(CLK_NS/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe && scl && prev_scl) sda_viol++;
    prev_oe  <= sda_oe;
    prev_scl <= scl;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] p);
    case (p)
      8'd0: exp_rd = m0;
      8'd1: exp_rd = {strap, m1en};
      8'd2: exp_rd = m2;
      8'd3: exp_rd = m3;
      8'd4: exp_rd = {mult, 7'b0};
      default: exp_rd = 8'h00;
    endcase
  endfunction

  task automatic mwr(input logic [7:0] p, input logic [7:0] d);
    case (p)
      8'd0: m0 = d;
      8'd1: m1en = d[2:0];
      8'd2: m2 = d;
      8'd3: m3 = d;
      default: ;
    endcase
  endtask

  task automatic wq; repeat (Q) @(negedge clk); endtask

  task automatic bit_io(input logic b, output logic r);
    sda_h = b;
    if (glitch_en) begin
      @(negedge clk); scl = 1'b1; @(negedge clk); scl = 1'b0;
    end
    wq; scl = 1'b1; wq; r = sda_line; wq; scl = 1'b0; wq;
  endtask

  task automatic start; sda_h = 1'b1; wq; scl = 1'b1; wq; sda_h = 1'b0; wq; scl = 1'b0; wq; endtask
  task automatic stop;  sda_h = 1'b0; wq; scl = 1'b1; wq; sda_h = 1'b1; wq; wq; endtask

  task automatic wbyte(input logic [7:0] d, output logic ackd);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(d[i], r);
    bit_io(1'b1, r);
    ackd = ~r;
  endtask

  task automatic rbyte(input logic last, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, r); d[i] = r; end
    bit_io(last, r);
  endtask

  task automatic chk_cfg(input string req);
    for (int k = 0; k < 5; k++) chk(req, 32'(cfg[8*k +: 8]), 32'(exp_rd(8'(k))));
  endtask

  task automatic do_write(input logic [7:0] n, input logic [7:0] x, input int nsend, input logic end_stop);
    logic a;
    start;
    wbyte(8'hD2, a); chk("R2 write address ack", 32'(a), 1);
    wbyte(n, a);     chk("R3 index ack", 32'(a), 1);
    midx = n;
    wbyte(x, a);     chk("R3 count ack", 32'(a), 1);
    mcnt = x;
    for (int i = 0; i < nsend; i++) begin
      wbyte(wd[i], a); chk("R4 R5 data ack", 32'(a), 1);
      if (i < int'(x)) mwr(n + 8'(i), wd[i]);
    end
    if (end_stop) stop;
  endtask

  task automatic do_read(input logic [7:0] n, input int nread, input logic with_idx);
    logic a;
    logic [7:0] d;
    if (with_idx) begin
      start;
      wbyte(8'hD2, a); chk("R2 write address ack", 32'(a), 1);
      wbyte(n, a);     chk("R6 index ack", 32'(a), 1);
      midx = n;
    end
    start;
    wbyte(8'hD3, a); chk("R2 read address ack", 32'(a), 1);
    rbyte(1'b0, d);  chk("R6 count byte", 32'(d), 32'(mcnt));
    for (int i = 0; i < nread; i++) begin
      rbyte(i == nread - 1, d);
      chk("R6 R5 read data", 32'(d), 32'(exp_rd(midx + 8'(i))));
    end
    chk("R6 released after NACK", 32'(sda_oe), 0);
    stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic a;
    logic r;
    int unsigned seed;
    strap = 5'b10110;
    mult  = 1'b1;
    seed  = $urandom(32'd4242);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_cfg("R1 R10 reset view");
    chk("R1 idle line", 32'(sda_oe), 0);

    start;
    wbyte(8'hA0, a); chk("R2 foreign address NACK", 32'(a), 0);
    wbyte(8'h00, a); chk("R2 silent after NACK", 32'(a), 0);
    stop;
    chk_cfg("R2 no change");

    wd[0] = 8'h11; wd[1] = 8'h22; wd[2] = 8'h33; wd[3] = 8'h44;
    do_write(8'd0, 8'd4, 4, 1'b1);
    chk_cfg("R3 R10 block write");

    wd[0] = 8'h00; do_write(8'd1, 8'd1, 1, 1'b1);
    wd[0] = 8'hFF; do_write(8'd4, 8'd1, 1, 1'b1);
    chk_cfg("R7 readback bits");
    strap = 5'b01001; mult = 1'b0;
    repeat (4) @(negedge clk);
    chk_cfg("R7 pins followed");

    wd[0] = 8'hA1; wd[1] = 8'hA2; wd[2] = 8'hA3; wd[3] = 8'hA4;
    do_write(8'd2, 8'd2, 4, 1'b1);
    chk_cfg("R4 surplus discarded");

    wd[0] = 8'h5C; wd[1] = 8'h66; wd[2] = 8'h77;
    do_write(8'd3, 8'd3, 3, 1'b1);
    chk_cfg("R5 out of range write");

    do_read(8'd0, 5, 1'b1);
    do_read(8'd3, 4, 1'b1);

    wd[0] = 8'hC3; wd[1] = 8'hD4;
    do_write(8'd2, 8'd2, 1, 1'b1);
    chk_cfg("R8 stop mid write");
    do_read(8'd0, 2, 1'b0);

    wd[0] = 8'h9E; wd[1] = 8'h8F;
    do_write(8'd0, 8'd3, 1, 1'b0);
    wd[0] = 8'h3C;
    do_write(8'd3, 8'd1, 1, 1'b1);
    chk_cfg("R8 start mid write");

    glitch_en = 1'b1;
    wd[0] = 8'h5A; wd[1] = 8'h06;
    do_write(8'd0, 8'd2, 2, 1'b1);
    glitch_en = 1'b0;
    chk_cfg("R9 glitch rejected");

    for (int it = 0; it < 18; it++) begin
      if ($urandom_range(1, 0) == 1) begin
        for (int i = 0; i < 4; i++) wd[i] = 8'($urandom);
        do_write(8'($urandom_range(6, 0)), 8'($urandom_range(4, 0)), int'($urandom_range(4, 0)), 1'b1);
        chk_cfg("R3 random write");
      end else begin
        do_read(8'($urandom_range(6, 0)), int'($urandom_range(4, 1)), 1'b1);
      end
    end

    chk("R9 SDA moved with SCL high", 32'(sda_viol), 0);
    r = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule